// File: doc/BRIEF.md
# Two-Codeword Symbol Interleaver with Linked Erasure

This block sits between a Reed-Solomon encoder/decoder pair and a multi-lane line interface. On the transmit side it takes a pair of codewords, A then B, each of `CW_LEN` symbols of `SYM_W` bits. It merges their symbols so that A and B alternate, and deals that merged stream round robin over `LANES` lanes, one full row of lanes at a time. Because neighbouring line symbols belong to different codewords, a burst of errors on the line is split between both codewords.

On the receive side the block takes the same rows and rebuilds A and B in row-wide memories. It then streams A followed by B, one symbol per cycle, with framing marks. A decoder reports one status record per codeword: an errored-symbol count and a failure flag. If either codeword of a pair is judged uncorrectable, every symbol of both codewords leaves with the bad flag set. Two receive banks let the next pair arrive while the previous one is still being read out.

Top module: `cw_pair_interleaver`

## Requirements
- R1: Line position k of a pair is placed in row k/LANES, lane k%LANES, and lane l occupies bits [l*SYM_W +: SYM_W] of the row word. Even k carries A symbol k/2 and odd k carries B symbol k/2, so even lanes hold A and odd lanes hold B.
- R2: The transmit input takes all A symbols in order, then all B symbols in order. A start mark on a symbol makes that symbol A[0]. After A[0] is marked, the following 2*CW_LEN valid symbols form one pair. Each pair yields exactly 2*CW_LEN/LANES rows, and the first row of the pair carries the first-row mark.
- R3: A transmit row is never valid in two consecutive cycles.
- R4: For each received pair, the receive output gives A symbols 0..CW_LEN-1 and then B symbols 0..CW_LEN-1, one per cycle with no gap inside the pair. The codeword tag is 0 for A and 1 for B. The start mark is on symbol 0 of each codeword and the end mark is on its last symbol.
- R5: Feeding the transmit rows straight into the receive inputs returns every pair unchanged.
- R6: A codeword counts as uncorrectable when its failure flag is set or its errored-symbol count exceeds CORR_LIMIT (default 15). A count of exactly CORR_LIMIT with no failure flag counts as correctable.
- R7: If either codeword of a pair is uncorrectable, the bad output is high on every symbol of both A and B of that pair. Otherwise it is low on all of them.
- R8: A status record applies to the pair whose rows are arriving. It may arrive from the cycle after the previous pair's last row up to and including the cycle of this pair's last row.
- R9: Rows of the next pair may be accepted while the previous pair is still being output. A completed pair waits for the output side. A pair must not be completed into a bank whose data has not yet been read out.
- R10: During and after reset, all valid, mark and bad outputs are low until data arrives.
- R11: A receive row with the first-row mark is stored as row 0 of a new pair, whatever partial pair came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Transmit symbol valid |
| tx_in_start | input | 1 | Marks the symbol as A[0] |
| tx_in_sym | input | SYM_W | Transmit symbol |
| tx_lane_valid | output | 1 | Transmit row valid |
| tx_lane_first | output | 1 | Row is the first of a pair |
| tx_lane_data | output | LANES*SYM_W | Transmit row, lane l at bits l*SYM_W |
| rx_lane_valid | input | 1 | Receive row valid |
| rx_lane_first | input | 1 | Receive row is the first of a pair |
| rx_lane_data | input | LANES*SYM_W | Receive row |
| stat_valid | input | 1 | Decoder status record valid (one codeword) |
| stat_errs | input | $clog2(CW_LEN+1) | Errored-symbol count of that codeword |
| stat_fail | input | 1 | Decoder failure flag of that codeword |
| out_valid | output | 1 | Receive output symbol valid |
| out_sym | output | SYM_W | Receive output symbol |
| out_sof | output | 1 | First symbol of a codeword |
| out_eof | output | 1 | Last symbol of a codeword |
| out_cw | output | 1 | Codeword tag, 0 = A, 1 = B |
| out_bad | output | 1 | Linked uncorrectable flag |

## Verification
The hardest case to reach from the ports is status timing against bank reuse. A record must land in the window of the pair it belongs to while the other bank is still being drained, so that a flag on one pair must neither leak into the next nor be lost. The stimulus sends pairs back to back, with random idle cycles in some of them. It places the A and B status records early in each pair's transmit phase, which falls after the previous pair's last row, and mixes directed counts at and just over the correctable limit with random records. A leading partial pair leaves the receive row counter part-way through a pair, so the realignment on the first-row mark is exercised before any real data.

// File: rtl/cwi_pkg.sv
package cwi_pkg;

  typedef enum logic {
    CW_A = 1'b0,
    CW_B = 1'b1
  } cw_id_e;

  // A codeword is past repair when the decoder gave up or when more symbols
  // were hit than the code can correct.
  function automatic logic judge_uncorrectable(input logic fail,
                                               input int unsigned errs,
                                               input int unsigned limit);
    return fail || (errs > limit);
  endfunction

endpackage

// File: rtl/cwi_sdp_ram.sv
module cwi_sdp_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 544,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cwi_tx_interleave.sv
module cwi_tx_interleave #(
  parameter int SYM_W  = 10,
  parameter int CW_LEN = 544,
  parameter int LANES  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_start,
  input  logic [SYM_W-1:0]       in_sym,
  output logic                   lane_valid,
  output logic                   lane_first,
  output logic [LANES*SYM_W-1:0] lane_data
);

  localparam int HALF     = LANES / 2;
  localparam int PAIR_LEN = 2 * CW_LEN;
  localparam int CNT_W    = $clog2(PAIR_LEN);
  localparam int AW       = $clog2(CW_LEN);
  localparam int SLOT_W   = $clog2(HALF);

  logic [CNT_W-1:0] cnt, pos;
  logic             in_b;
  logic [AW-1:0]    b_idx;
  logic [SYM_W-1:0] a_sym;

  // position of the incoming symbol within its pair
  always_comb begin
    pos   = in_start ? '0 : cnt;
    in_b  = pos >= CNT_W'(CW_LEN);
    b_idx = AW'(pos - CNT_W'(CW_LEN));
  end

  // codeword A is parked here until its partner symbol of B shows up
  cwi_sdp_ram #(.W(SYM_W), .DEPTH(CW_LEN), .AW(AW)) u_a_store (
    .clk   (clk),
    .we    (in_valid && !in_b),
    .waddr (AW'(pos)),
    .wdata (in_sym),
    .raddr (b_idx),
    .rdata (a_sym)
  );

  logic             b_v;
  logic [SYM_W-1:0] b_sym;
  logic [AW-1:0]    b_j;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      b_v   <= 1'b0;
      b_sym <= '0;
      b_j   <= '0;
    end else begin
      b_v <= in_valid && in_b;
      if (in_valid) begin
        cnt   <= (pos == CNT_W'(PAIR_LEN - 1)) ? '0 : pos + 1'b1;
        b_sym <= in_sym;
        b_j   <= b_idx;
      end
    end
  end

  // each B symbol drops an (A, B) couple into two adjacent lanes of the row
  logic [SLOT_W-1:0]      slot;
  logic [LANES*SYM_W-1:0] row_buf, row_next;

  always_comb begin
    slot     = b_j[SLOT_W-1:0];
    row_next = row_buf;
    row_next[(2 * slot) * SYM_W +: SYM_W]     = a_sym;
    row_next[(2 * slot + 1) * SYM_W +: SYM_W] = b_sym;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_buf    <= '0;
      lane_valid <= 1'b0;
      lane_first <= 1'b0;
      lane_data  <= '0;
    end else begin
      lane_valid <= 1'b0;
      if (b_v) begin
        row_buf <= row_next;
        if (slot == SLOT_W'(HALF - 1)) begin
          lane_valid <= 1'b1;
          lane_first <= b_j < AW'(HALF);
          lane_data  <= row_next;
        end
      end
    end
  end

  // a row needs HALF B symbols, so two rows can never be back to back
  assert_row_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    lane_valid |=> !lane_valid);

endmodule

// File: rtl/cwi_rx_store.sv
module cwi_rx_store #(
  parameter int SYM_W      = 10,
  parameter int CW_LEN     = 544,
  parameter int LANES      = 16,
  parameter int CORR_LIMIT = 15,
  parameter int ERR_W      = 10,
  parameter int ROW_W      = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    row_valid,
  input  logic                    row_first,
  input  logic [LANES*SYM_W-1:0]  row_data,
  input  logic                    stat_valid,
  input  logic [ERR_W-1:0]        stat_errs,
  input  logic                    stat_fail,
  input  logic                    rd_bank,
  input  logic [ROW_W-1:0]        rd_row,
  input  logic                    rd_cw,
  output logic [LANES/2*SYM_W-1:0] rd_data,
  input  logic                    release_valid,
  input  logic                    release_bank,
  output logic [1:0]              pend,
  output logic [1:0]              bad
);

  import cwi_pkg::*;

  localparam int HALF   = LANES / 2;
  localparam int HALF_W = HALF * SYM_W;
  localparam int ROWS   = 2 * CW_LEN / LANES;
  localparam int AW     = ROW_W + 1;
  localparam int DEPTH  = 2 ** AW;

  logic [HALF_W-1:0] a_word, b_word, a_q, b_q;

  for (genvar h = 0; h < HALF; h++) begin : g_split
    assign a_word[h * SYM_W +: SYM_W] = row_data[(2 * h) * SYM_W +: SYM_W];
    assign b_word[h * SYM_W +: SYM_W] = row_data[(2 * h + 1) * SYM_W +: SYM_W];
  end

  logic [ROW_W-1:0] wr_row, row_idx;
  logic             wb, complete, stat_bad, acc;

  always_comb begin
    row_idx  = row_first ? '0 : wr_row;
    complete = row_valid && (row_idx == ROW_W'(ROWS - 1));
    stat_bad = stat_valid && judge_uncorrectable(stat_fail, 32'(stat_errs), CORR_LIMIT);
  end

  cwi_sdp_ram #(.W(HALF_W), .DEPTH(DEPTH), .AW(AW)) u_mem_a (
    .clk(clk), .we(row_valid), .waddr({wb, row_idx}), .wdata(a_word),
    .raddr({rd_bank, rd_row}), .rdata(a_q)
  );

  cwi_sdp_ram #(.W(HALF_W), .DEPTH(DEPTH), .AW(AW)) u_mem_b (
    .clk(clk), .we(row_valid), .waddr({wb, row_idx}), .wdata(b_word),
    .raddr({rd_bank, rd_row}), .rdata(b_q)
  );

  logic cw_q;
  assign rd_data = cw_q ? b_q : a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_row <= '0;
      wb     <= 1'b0;
      acc    <= 1'b0;
      pend   <= '0;
      bad    <= '0;
      cw_q   <= 1'b0;
    end else begin
      cw_q <= rd_cw;
      if (row_valid) wr_row <= complete ? '0 : row_idx + 1'b1;
      if (complete) begin
        wb      <= ~wb;
        acc     <= 1'b0;
        bad[wb] <= acc || stat_bad;
      end else if (stat_bad) begin
        acc <= 1'b1;
      end
      if (release_valid) pend[release_bank] <= 1'b0;
      if (complete)      pend[wb] <= 1'b1;
    end
  end

  // a finished pair may only land in a bank the output side has let go
  assert_bank_free_R9: assert property (@(posedge clk) disable iff (rst)
    complete |-> (!pend[wb] || (release_valid && release_bank == wb)));

endmodule

// File: rtl/cwi_rx_drain.sv
module cwi_rx_drain #(
  parameter int SYM_W  = 10,
  parameter int CW_LEN = 544,
  parameter int LANES  = 16,
  parameter int ROW_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               pend,
  input  logic [1:0]               bad,
  output logic                     rd_bank,
  output logic [ROW_W-1:0]         rd_row,
  output logic                     rd_cw,
  input  logic [LANES/2*SYM_W-1:0] rd_data,
  output logic                     release_valid,
  output logic                     release_bank,
  output logic                     out_valid,
  output logic [SYM_W-1:0]         out_sym,
  output logic                     out_sof,
  output logic                     out_eof,
  output logic                     out_cw,
  output logic                     out_bad
);

  import cwi_pkg::*;

  localparam int HALF     = LANES / 2;
  localparam int PAIR_LEN = 2 * CW_LEN;
  localparam int IDX_W    = $clog2(PAIR_LEN);
  localparam int JW       = $clog2(CW_LEN);
  localparam int SLOT_W   = $clog2(HALF);

  logic             busy, rb, cur_bad, last;
  logic [IDX_W-1:0] idx;
  cw_id_e           cur_cw;
  logic [JW-1:0]    j;

  always_comb begin
    cur_cw = (idx >= IDX_W'(CW_LEN)) ? CW_B : CW_A;
    j      = (cur_cw == CW_B) ? JW'(idx - IDX_W'(CW_LEN)) : JW'(idx);
    last   = busy && (idx == IDX_W'(PAIR_LEN - 1));
  end

  assign rd_bank       = rb;
  assign rd_row        = ROW_W'(j >> SLOT_W);
  assign rd_cw         = cur_cw;
  assign release_valid = last;
  assign release_bank  = rb;

  logic              s1_v, s1_sof, s1_eof, s1_bad;
  logic [SLOT_W-1:0] s1_slot;
  cw_id_e            s1_cw;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rb        <= 1'b0;
      idx       <= '0;
      cur_bad   <= 1'b0;
      s1_v      <= 1'b0;
      s1_sof    <= 1'b0;
      s1_eof    <= 1'b0;
      s1_bad    <= 1'b0;
      s1_slot   <= '0;
      s1_cw     <= CW_A;
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_cw    <= 1'b0;
      out_bad   <= 1'b0;
    end else begin
      if (!busy) begin
        if (pend[rb]) begin
          busy    <= 1'b1;
          idx     <= '0;
          cur_bad <= bad[rb];
        end
      end else if (last) begin
        busy <= 1'b0;
        rb   <= ~rb;
      end else begin
        idx <= idx + 1'b1;
      end
      // stage 1: memory word is being fetched
      s1_v    <= busy;
      s1_slot <= j[SLOT_W-1:0];
      s1_cw   <= cur_cw;
      s1_sof  <= busy && (j == '0);
      s1_eof  <= busy && (j == JW'(CW_LEN - 1));
      s1_bad  <= busy && cur_bad;
      // stage 2: pick the symbol out of the row word
      out_valid <= s1_v;
      out_sym   <= rd_data[s1_slot * SYM_W +: SYM_W];
      out_sof   <= s1_sof;
      out_eof   <= s1_eof;
      out_cw    <= s1_cw;
      out_bad   <= s1_bad;
    end
  end

  assert_pair_contiguous_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_eof && out_cw == CW_B)) |=> out_valid);

  assert_b_follows_a_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof && out_cw == CW_B) |-> ($past(out_eof) && $past(out_cw) == CW_A));

  assert_bad_linked_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && !(out_sof && out_cw == CW_A)) |-> (out_bad == $past(out_bad)));

endmodule

// File: rtl/cw_pair_interleaver.sv
module cw_pair_interleaver #(
  parameter int SYM_W      = 10,
  parameter int CW_LEN     = 544,
  parameter int LANES      = 16,
  parameter int CORR_LIMIT = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_in_valid,
  input  logic                        tx_in_start,
  input  logic [SYM_W-1:0]            tx_in_sym,
  output logic                        tx_lane_valid,
  output logic                        tx_lane_first,
  output logic [LANES*SYM_W-1:0]      tx_lane_data,
  input  logic                        rx_lane_valid,
  input  logic                        rx_lane_first,
  input  logic [LANES*SYM_W-1:0]      rx_lane_data,
  input  logic                        stat_valid,
  input  logic [$clog2(CW_LEN+1)-1:0] stat_errs,
  input  logic                        stat_fail,
  output logic                        out_valid,
  output logic [SYM_W-1:0]            out_sym,
  output logic                        out_sof,
  output logic                        out_eof,
  output logic                        out_cw,
  output logic                        out_bad
);

  localparam int ERR_W  = $clog2(CW_LEN + 1);
  localparam int ROWS   = 2 * CW_LEN / LANES;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int HALF_W = LANES / 2 * SYM_W;

  cwi_tx_interleave #(.SYM_W(SYM_W), .CW_LEN(CW_LEN), .LANES(LANES)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (tx_in_valid),
    .in_start   (tx_in_start),
    .in_sym     (tx_in_sym),
    .lane_valid (tx_lane_valid),
    .lane_first (tx_lane_first),
    .lane_data  (tx_lane_data)
  );

  logic              rd_bank, rd_cw, rel_v, rel_bank;
  logic [ROW_W-1:0]  rd_row;
  logic [HALF_W-1:0] rd_data;
  logic [1:0]        pend, bad;

  cwi_rx_store #(
    .SYM_W(SYM_W), .CW_LEN(CW_LEN), .LANES(LANES),
    .CORR_LIMIT(CORR_LIMIT), .ERR_W(ERR_W), .ROW_W(ROW_W)
  ) u_store (
    .clk           (clk),
    .rst           (rst),
    .row_valid     (rx_lane_valid),
    .row_first     (rx_lane_first),
    .row_data      (rx_lane_data),
    .stat_valid    (stat_valid),
    .stat_errs     (stat_errs),
    .stat_fail     (stat_fail),
    .rd_bank       (rd_bank),
    .rd_row        (rd_row),
    .rd_cw         (rd_cw),
    .rd_data       (rd_data),
    .release_valid (rel_v),
    .release_bank  (rel_bank),
    .pend          (pend),
    .bad           (bad)
  );

  cwi_rx_drain #(.SYM_W(SYM_W), .CW_LEN(CW_LEN), .LANES(LANES), .ROW_W(ROW_W)) u_drain (
    .clk           (clk),
    .rst           (rst),
    .pend          (pend),
    .bad           (bad),
    .rd_bank       (rd_bank),
    .rd_row        (rd_row),
    .rd_cw         (rd_cw),
    .rd_data       (rd_data),
    .release_valid (rel_v),
    .release_bank  (rel_bank),
    .out_valid     (out_valid),
    .out_sym       (out_sym),
    .out_sof       (out_sof),
    .out_eof       (out_eof),
    .out_cw        (out_cw),
    .out_bad       (out_bad)
  );

endmodule

// File: tb/cw_pair_interleaver_test.sv
module cw_pair_interleaver_test;

  localparam int SYM_W  = 10;
  localparam int CW_LEN = 544;
  localparam int LANES  = 16;
  localparam int LIMIT  = 15;
  localparam int ROWS   = 2 * CW_LEN / LANES;
  localparam int W      = LANES * SYM_W;
  localparam int ERR_W  = $clog2(CW_LEN + 1);
  localparam int NP     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              tx_in_valid = 0, tx_in_start = 0;
  logic [SYM_W-1:0]  tx_in_sym = '0;
  logic              tx_lane_valid, tx_lane_first;
  logic [W-1:0]      tx_lane_data;
  logic              stat_valid = 0, stat_fail = 0;
  logic [ERR_W-1:0]  stat_errs = '0;
  logic              out_valid, out_sof, out_eof, out_cw, out_bad;
  logic [SYM_W-1:0]  out_sym;

  cw_pair_interleaver #(.SYM_W(SYM_W), .CW_LEN(CW_LEN), .LANES(LANES), .CORR_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst),
    .tx_in_valid(tx_in_valid), .tx_in_start(tx_in_start), .tx_in_sym(tx_in_sym),
    .tx_lane_valid(tx_lane_valid), .tx_lane_first(tx_lane_first), .tx_lane_data(tx_lane_data),
    .rx_lane_valid(tx_lane_valid), .rx_lane_first(tx_lane_first), .rx_lane_data(tx_lane_data),
    .stat_valid(stat_valid), .stat_errs(stat_errs), .stat_fail(stat_fail),
    .out_valid(out_valid), .out_sym(out_sym), .out_sof(out_sof), .out_eof(out_eof),
    .out_cw(out_cw), .out_bad(out_bad)
  );

  int checks = 0;
  int errors = 0;
  int unsigned pa [NP][CW_LEN];
  int unsigned pb [NP][CW_LEN];
  bit pbad [NP];
  bit skip_tx = 1'b0;
  int trow = 0;
  int opair = 0;
  int oidx = 0;
  bit prev_row = 1'b0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R6 judged from the requirement: failure flag, or count above the limit
  function automatic bit uncorr(input int errs, input bit fail);
    return fail || (errs > LIMIT);
  endfunction

  // R8: status records go out early in the pair's A phase, after the
  // previous pair's last row and well before this pair's last row
  task automatic send_pair(input int n, input int ea, input bit fa,
                           input int eb, input bit fb, input bit gaps);
    for (int k = 0; k < 2 * CW_LEN; k++) begin
      if (gaps && $urandom_range(3) == 0) begin
        @(negedge clk);
        tx_in_valid = 0; tx_in_start = 0; stat_valid = 0;
      end
      @(negedge clk);
      tx_in_valid = 1;
      tx_in_start = (k == 0);
      tx_in_sym   = (k < CW_LEN) ? SYM_W'(pa[n][k]) : SYM_W'(pb[n][k - CW_LEN]);
      stat_valid  = (k == 100) || (k == 101);
      stat_errs   = (k == 100) ? ERR_W'(ea) : ERR_W'(eb);
      stat_fail   = (k == 100) ? fa : fb;
    end
    @(negedge clk);
    tx_in_valid = 0; tx_in_start = 0; stat_valid = 0;
  endtask

  // R1 R2 R3: every transmit row against the placement rule
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_lane_valid && !skip_tx) begin
        logic [W-1:0] ev;
        int n, r;
        n = trow / ROWS;
        r = trow % ROWS;
        ev = '0;
        for (int l = 0; l < LANES; l++) begin
          int k;
          k = r * LANES + l;
          ev[l * SYM_W +: SYM_W] = (k % 2 == 0) ? SYM_W'(pa[n][k / 2]) : SYM_W'(pb[n][k / 2]);
        end
        check(tx_lane_data == ev, "R1 row placement", tx_lane_data, ev);
        check(tx_lane_first == (r == 0), "R2 first-row mark", W'(tx_lane_first), W'(r == 0));
        trow++;
      end
      if (tx_lane_valid)
        check(!prev_row, "R3 row spacing", W'(prev_row), W'(0));
      prev_row = tx_lane_valid;
    end
  end

  // R4 R5 R7: receive stream against the pairs that were sent
  always @(negedge clk) begin
    if (!rst && out_valid && opair < NP) begin
      logic [W-1:0] act, exp;
      bit isb;
      int j;
      isb = oidx >= CW_LEN;
      j = isb ? oidx - CW_LEN : oidx;
      act = W'({out_sym, out_sof, out_eof, out_cw});
      exp = W'({isb ? SYM_W'(pb[opair][j]) : SYM_W'(pa[opair][j]),
                j == 0, j == CW_LEN - 1, isb});
      check(act == exp, "R4 R5 loopback symbol and framing", act, exp);
      check(out_bad == pbad[opair], "R6 R7 R8 linked bad", W'(out_bad), W'(pbad[opair]));
      oidx++;
      if (oidx == 2 * CW_LEN) begin
        oidx = 0;
        opair++;
      end
    end
  end

  initial begin
    for (int n = 0; n < NP; n++)
      for (int i = 0; i < CW_LEN; i++) begin
        pa[n][i] = $urandom(32'h1234 + n * CW_LEN + i) & 32'h3ff;
        pb[n][i] = $urandom & 32'h3ff;
      end

    repeat (4) @(negedge clk);
    // R10 reset state
    check(!tx_lane_valid && !out_valid && !out_bad && !out_sof && !out_eof,
          "R10 reset outputs", W'({tx_lane_valid, out_valid, out_bad, out_sof, out_eof}), W'(0));
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!tx_lane_valid && !out_valid, "R10 idle after reset",
          W'({tx_lane_valid, out_valid}), W'(0));

    // R2 R11: a partial pair leaves both row counters mid-pair
    skip_tx = 1'b1;
    for (int k = 0; k < CW_LEN + 40; k++) begin
      @(negedge clk);
      tx_in_valid = 1; tx_in_start = (k == 0); tx_in_sym = SYM_W'($urandom);
    end
    @(negedge clk);
    tx_in_valid = 0; tx_in_start = 0;
    repeat (6) @(negedge clk);
    skip_tx = 1'b0;

    fork
      begin
        // directed cases, then random status
        pbad[0] = 0;                                  send_pair(0, 0, 0, 0, 0, 0);
        pbad[1] = uncorr(16, 0);                      send_pair(1, 16, 0, 0, 0, 0);  // R6 A only -> R7 both
        pbad[2] = uncorr(15, 0) || uncorr(15, 0);     send_pair(2, 15, 0, 15, 0, 1); // R6 at the limit
        pbad[3] = uncorr(3, 1);                       send_pair(3, 0, 0, 3, 1, 0);   // B failure flag
        pbad[4] = uncorr(CW_LEN, 0);                  send_pair(4, CW_LEN, 0, 0, 0, 1);
        for (int n = 5; n < NP; n++) begin
          int ea, eb;
          bit fa, fb;
          ea = $urandom_range(20); eb = $urandom_range(20);
          fa = ($urandom_range(7) == 0); fb = ($urandom_range(7) == 0);
          pbad[n] = uncorr(ea, fa) || uncorr(eb, fb);
          send_pair(n, ea, fa, eb, fb, n[0]);
        end
      end
      begin
        fork
          wait (opair == NP);
          begin
            repeat (150000) @(posedge clk);
            checks++; errors++;
            $display("FAIL R4 watchdog: pairs out %0d expected %0d", opair, NP);
          end
        join_any
        disable fork;
      end
    join

    repeat (4) @(negedge clk);
    check(trow == NP * ROWS, "R2 row count", W'(trow), W'(NP * ROWS));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule